// File: doc/BRIEF.md
# Instrument Status Byte and Service-Request Logic

This block is the status-reporting core of a programmable instrument. Two groups of event flags are kept: a standard group (8 bits) and an extended group (parameter width). Each group is latched from single-cycle event pulses into a sticky event register and reduced to one summary bit through its own enable mask. The two summaries and the not-empty flags of the error queue and the output queue form an 8-bit status byte. That byte is masked by a service-request enable register to give a master summary.

The master summary is a level. A separate request-service flag is set on the rising edge of the master summary. It is cleared either when the host performs a serial poll or when the summary drops back to zero. The flag drives the service-request output line directly. The host reaches the enable registers, the event registers and a status query through a small address-decoded port. It acknowledges a request by pulsing the serial-poll strobe while it reads the poll byte.

Top module: `statusReporter`

## Requirements
- R1: After reset, every register is zero: the poll byte reads 0x00, srqOut is low, and every address reads 0.
- R2: Status-byte bits 7, 1 and 0 are always 0. Bit 2 equals errQueueNotEmpty and bit 4 equals outQueueNotEmpty.
- R3: Status-byte bit 5 is 1 exactly when (standard events AND standard enable) is nonzero. Bit 3 is 1 exactly when (extended events AND extended enable) is nonzero.
- R4: Event bits are sticky: a one-cycle pulse sets a bit, and the bit stays set until a read. A read of address 2 (standard) or address 4 (extended) returns the current value and clears the register at that clock edge. A pulse that arrives in the same cycle as the clearing read is kept.
- R5: The master summary is 1 exactly when (status byte with bit 6 excluded) AND (service-request enable) is nonzero. A status query at address 0 returns the status byte with the master summary in bit 6 and does not clear the request-service flag.
- R6: A write to the service-request enable register (address 1) stores every bit except bit 6, which always reads 0. An enable bit at 0 keeps its status bit out of the master summary even when that status bit is 1.
- R7: The request-service flag is set at the first clock edge at which the master summary is 1 after having been 0. srqOut always equals the flag.
- R8: A serialPoll pulse clears the flag at that clock edge. pollByte carries the flag in bit 6 and the other status bits unchanged. If a rising master summary coincides with the poll, the flag is set.
- R9: At a clock edge where the master summary is 0, the flag is cleared.
- R10: Address 3 is the standard enable register and address 5 the extended enable register, both read/write. Addresses 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stdEventPulse | input | 8 | Standard event pulses, one cycle each |
| extEventPulse | input | EXT_W | Extended event pulses, one cycle each |
| errQueueNotEmpty | input | 1 | Error queue holds an entry |
| outQueueNotEmpty | input | 1 | Output queue holds a response |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; clears event registers it reads |
| regAddr | input | 3 | Register address |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data, combinational, 0 when no read |
| serialPoll | input | 1 | Serial-poll acknowledge strobe |
| pollByte | output | 8 | Status byte with request-service flag in bit 6 |
| srqOut | output | 1 | Service-request line |

## Verification
The bench aims at the difference between the flag and the summary. A poll must clear only the flag, and a status query must clear neither. A design that tied the flag to the level would hold srqOut high after a poll. A design that let a query clear the flag would drop a pending request. The bench also pulses an event in the same cycle as the read that clears it, where a design with the wrong priority loses the event. It writes all ones to the enable register to catch a design that stores bit 6. It lets the summary fall and rise again to catch a flag that fails to rearm.

// File: rtl/statusPkg.sv
package statusPkg;

  typedef enum logic [2:0] {
    ADDR_QUERY  = 3'd0,
    ADDR_SRE    = 3'd1,
    ADDR_STDEVT = 3'd2,
    ADDR_STDEN  = 3'd3,
    ADDR_EXTEVT = 3'd4,
    ADDR_EXTEN  = 3'd5
  } regAddrE;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrSre;
    logic       wrStdEn;
    logic       wrExtEn;
    logic       clrStd;
    logic       clrExt;
    logic       pollClr;
    logic       rdValid;
    logic [2:0] rdSel;
  } strobeT;

  localparam int SB_EAV = 2;
  localparam int SB_EXT = 3;
  localparam int SB_MAV = 4;
  localparam int SB_ESB = 5;
  localparam int SB_RQS = 6;

endpackage

// File: rtl/statusCtrl.sv
module statusCtrl
  import statusPkg::*;
(
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [2:0] regAddr,
  input  logic       serialPoll,
  output strobeT     strb
);

  always_comb begin
    strb = '0;
    strb.rdValid = regRdEn;
    strb.rdSel   = regAddr;
    strb.pollClr = serialPoll;
    if (regWrEn) begin
      case (regAddr)
        ADDR_SRE:   strb.wrSre   = 1'b1;
        ADDR_STDEN: strb.wrStdEn = 1'b1;
        ADDR_EXTEN: strb.wrExtEn = 1'b1;
        default:    ;
      endcase
    end
    if (regRdEn) begin
      case (regAddr)
        ADDR_STDEVT: strb.clrStd = 1'b1;
        ADDR_EXTEVT: strb.clrExt = 1'b1;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/statusEventGroup.sv
module statusEventGroup #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pulse,
  input  logic         clr,
  input  logic         enWr,
  input  logic [W-1:0] enData,
  output logic [W-1:0] evtQ,
  output logic [W-1:0] enQ,
  output logic         summary
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtQ <= '0;
      enQ  <= '0;
    end else begin
      evtQ <= (clr ? '0 : evtQ) | pulse;
      if (enWr) enQ <= enData;
    end
  end

  assign summary = |(evtQ & enQ);

  // R4: without a clearing read no set bit is lost
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    !clr |=> ((evtQ & $past(evtQ)) == $past(evtQ)));

  // R4: a clearing read leaves only the pulses of that cycle
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (evtQ == $past(pulse)));

endmodule

// File: rtl/statusPath.sv
module statusPath
  import statusPkg::*;
#(
  parameter int EXT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [7:0]        stdEventPulse,
  input  logic [EXT_W-1:0]  extEventPulse,
  input  logic              errQueueNotEmpty,
  input  logic              outQueueNotEmpty,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [7:0]        pollByte,
  output logic              srqOut
);

  localparam int STD_W = 8;

  logic [STD_W-1:0] stdEvt, stdEn;
  logic [EXT_W-1:0] extEvt, extEn;
  logic             stdSum, extSum;
  logic [7:0]       sreQ;
  logic [7:0]       sbBase;
  logic [7:0]       queryByte;
  logic             mss, mssQ, rqsQ, mssRise;

  statusEventGroup #(.W(STD_W)) u_std (
    .clk(clk), .rstN(rstN), .pulse(stdEventPulse), .clr(strb.clrStd),
    .enWr(strb.wrStdEn), .enData(regWrData[STD_W-1:0]),
    .evtQ(stdEvt), .enQ(stdEn), .summary(stdSum));

  statusEventGroup #(.W(EXT_W)) u_ext (
    .clk(clk), .rstN(rstN), .pulse(extEventPulse), .clr(strb.clrExt),
    .enWr(strb.wrExtEn), .enData(regWrData[EXT_W-1:0]),
    .evtQ(extEvt), .enQ(extEn), .summary(extSum));

  always_comb begin
    sbBase         = '0;
    sbBase[SB_EAV] = errQueueNotEmpty;
    sbBase[SB_EXT] = extSum;
    sbBase[SB_MAV] = outQueueNotEmpty;
    sbBase[SB_ESB] = stdSum;
  end

  assign mss     = |(sbBase & sreQ);
  assign mssRise = mss & ~mssQ;

  always_comb begin
    queryByte         = sbBase;
    queryByte[SB_RQS] = mss;
    pollByte          = sbBase;
    pollByte[SB_RQS]  = rqsQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sreQ <= '0;
      mssQ <= 1'b0;
      rqsQ <= 1'b0;
    end else begin
      if (strb.wrSre) begin
        sreQ         <= regWrData[7:0];
        sreQ[SB_RQS] <= 1'b0;
      end
      mssQ <= mss;
      if (!mss)              rqsQ <= 1'b0;
      else if (mssRise)      rqsQ <= 1'b1;
      else if (strb.pollClr) rqsQ <= 1'b0;
    end
  end

  assign srqOut = rqsQ;

  always_comb begin
    regRdData = '0;
    if (strb.rdValid) begin
      case (strb.rdSel)
        ADDR_QUERY:  regRdData = DATA_W'(queryByte);
        ADDR_SRE:    regRdData = DATA_W'(sreQ);
        ADDR_STDEVT: regRdData = DATA_W'(stdEvt);
        ADDR_STDEN:  regRdData = DATA_W'(stdEn);
        ADDR_EXTEVT: regRdData = DATA_W'(extEvt);
        ADDR_EXTEN:  regRdData = DATA_W'(extEn);
        default:     regRdData = '0;
      endcase
    end
  end

  assert_rqs_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mss && !mssQ) |=> rqsQ);

  assert_rqs_poll_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pollClr && mssQ) |=> !rqsQ);

  assert_rqs_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    !mss |=> !srqOut);

  assert_sre_bit6_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSre |=> (!sreQ[SB_RQS] && sreQ[5:0] == $past(regWrData[5:0])));

endmodule

// File: rtl/statusReporter.sv
module statusReporter
  import statusPkg::*;
#(
  parameter int EXT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        stdEventPulse,
  input  logic [EXT_W-1:0]  extEventPulse,
  input  logic              errQueueNotEmpty,
  input  logic              outQueueNotEmpty,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              serialPoll,
  output logic [7:0]        pollByte,
  output logic              srqOut
);

  strobeT strb;

  statusCtrl u_ctrl (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .serialPoll(serialPoll), .strb(strb));

  statusPath #(.EXT_W(EXT_W), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb),
    .stdEventPulse(stdEventPulse), .extEventPulse(extEventPulse),
    .errQueueNotEmpty(errQueueNotEmpty), .outQueueNotEmpty(outQueueNotEmpty),
    .regWrData(regWrData), .regRdData(regRdData),
    .pollByte(pollByte), .srqOut(srqOut));

endmodule

// File: tb/statusReporter_tb.sv
module statusReporter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int EXT_W  = 16;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [7:0]        stdEventPulse = '0;
  logic [EXT_W-1:0]  extEventPulse = '0;
  logic              errQueueNotEmpty = 1'b0;
  logic              outQueueNotEmpty = 1'b0;
  logic              regWrEn = 1'b0;
  logic              regRdEn = 1'b0;
  logic [2:0]        regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic              serialPoll = 1'b0;
  logic [7:0]        pollByte;
  logic              srqOut;

  int checks = 0;
  int errs   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  statusReporter #(.EXT_W(EXT_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .stdEventPulse(stdEventPulse),
    .extEventPulse(extEventPulse), .errQueueNotEmpty(errQueueNotEmpty),
    .outQueueNotEmpty(outQueueNotEmpty), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .serialPoll(serialPoll), .pollByte(pollByte), .srqOut(srqOut));

  typedef struct packed {
    logic        err;
    logic        out;
    logic [7:0]  sre;
    logic [7:0]  stdEn;
    logic [15:0] extEn;
    logic [7:0]  stdP;
    logic [15:0] extP;
    logic [7:0]  exp;
  } vecT;

  // expected = status query byte (bit 6 = master summary)
  localparam vecT VECS [7] = '{
    '{1'b1, 1'b0, 8'h04, 8'h00, 16'h0000, 8'h00, 16'h0000, 8'h44},
    '{1'b0, 1'b1, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, 8'h10},
    '{1'b0, 1'b0, 8'h20, 8'h01, 16'h0000, 8'h21, 16'h0000, 8'h60},
    '{1'b0, 1'b0, 8'h20, 8'h01, 16'h0000, 8'h02, 16'h0000, 8'h00},
    '{1'b0, 1'b0, 8'h08, 8'h00, 16'h8000, 8'h00, 16'h8000, 8'h48},
    '{1'b1, 1'b1, 8'hFF, 8'h00, 16'h8000, 8'h00, 16'h0100, 8'h54},
    '{1'b1, 1'b1, 8'h40, 8'h00, 16'h0000, 8'h00, 16'h0000, 8'h14}
  };

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pulseEvents(input logic [7:0] s, input logic [15:0] e);
    @(negedge clk);
    stdEventPulse = s; extEventPulse = e;
    @(negedge clk);
    stdEventPulse = '0; extEventPulse = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pollByte", DATA_W'(pollByte), 16'h0000);
    check("R1 srqOut", DATA_W'(srqOut), 16'h0000);
    for (int a = 0; a < 8; a++) begin
      readReg(3'(a), rd);
      check("R1 reg", rd, 16'h0000);
    end

    // table walk: R2 R3 R5 R6
    foreach (VECS[i]) begin
      writeReg(3'd1, DATA_W'(VECS[i].sre));
      writeReg(3'd3, DATA_W'(VECS[i].stdEn));
      writeReg(3'd5, VECS[i].extEn);
      errQueueNotEmpty = VECS[i].err;
      outQueueNotEmpty = VECS[i].out;
      pulseEvents(VECS[i].stdP, VECS[i].extP);
      readReg(3'd0, rd);
      check("R2/R3/R5/R6 query", rd, DATA_W'(VECS[i].exp));
      check("R2 unused bits", DATA_W'({pollByte[7], pollByte[1:0]}), 16'h0000);
      errQueueNotEmpty = 1'b0;
      outQueueNotEmpty = 1'b0;
      readReg(3'd2, rd);
      readReg(3'd4, rd);
    end

    // R6 bit 6 ignored on write
    writeReg(3'd1, 16'h00FF);
    readReg(3'd1, rd);
    check("R6 sre readback", rd, 16'h00BF);

    // R10 enable registers and unmapped addresses
    writeReg(3'd3, 16'h00A5);
    writeReg(3'd5, 16'h1234);
    writeReg(3'd6, 16'hFFFF);
    writeReg(3'd7, 16'hFFFF);
    readReg(3'd3, rd);
    check("R10 std enable", rd, 16'h00A5);
    readReg(3'd5, rd);
    check("R10 ext enable", rd, 16'h1234);
    readReg(3'd6, rd);
    check("R10 addr6", rd, 16'h0000);
    readReg(3'd7, rd);
    check("R10 addr7", rd, 16'h0000);
    readReg(3'd1, rd);
    check("R10 sre untouched", rd, 16'h00BF);

    // R4 sticky and read-clear
    pulseEvents(8'h01, 16'h0000);
    repeat (2) @(negedge clk);
    readReg(3'd2, rd);
    check("R4 sticky", rd, 16'h0001);
    readReg(3'd2, rd);
    check("R4 cleared", rd, 16'h0000);
    @(negedge clk);
    stdEventPulse = 8'h10;
    @(negedge clk);
    stdEventPulse = 8'h00;
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 3'd2; stdEventPulse = 8'h04;
    #1 rd = regRdData;
    check("R4 read value", rd, 16'h0010);
    @(negedge clk);
    regRdEn = 1'b0; stdEventPulse = 8'h00;
    readReg(3'd2, rd);
    check("R4 pulse kept", rd, 16'h0004);

    // R7 R8 R9 request-service flag
    writeReg(3'd1, 16'h0004);
    writeReg(3'd3, 16'h0000);
    writeReg(3'd5, 16'h0000);
    check("R9 idle", DATA_W'(srqOut), 16'h0000);
    @(negedge clk);
    errQueueNotEmpty = 1'b1;
    @(negedge clk);
    check("R7 srq set", DATA_W'(srqOut), 16'h0001);
    check("R8 poll byte", DATA_W'(pollByte), 16'h0044);
    readReg(3'd0, rd);
    check("R5 query", rd, 16'h0044);
    check("R5 query keeps flag", DATA_W'(srqOut), 16'h0001);
    @(negedge clk);
    serialPoll = 1'b1;
    @(negedge clk);
    serialPoll = 1'b0;
    check("R8 poll clears", DATA_W'(srqOut), 16'h0000);
    check("R8 poll byte after", DATA_W'(pollByte), 16'h0004);
    readReg(3'd0, rd);
    check("R5 mss stays", rd, 16'h0044);
    repeat (3) @(negedge clk);
    check("R7 no rearm without edge", DATA_W'(srqOut), 16'h0000);
    errQueueNotEmpty = 1'b0;
    @(negedge clk);
    errQueueNotEmpty = 1'b1; serialPoll = 1'b1;
    @(negedge clk);
    serialPoll = 1'b0;
    check("R8 rise beats poll", DATA_W'(srqOut), 16'h0001);
    errQueueNotEmpty = 1'b0;
    @(negedge clk);
    check("R9 fall clears", DATA_W'(srqOut), 16'h0000);

    // R6 masked bit gives no request
    writeReg(3'd1, 16'h0010);
    errQueueNotEmpty = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 masked srq", DATA_W'(srqOut), 16'h0000);
    readReg(3'd0, rd);
    check("R6 masked query", rd, 16'h0004);
    errQueueNotEmpty = 1'b0;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule